// File: doc/BRIEF.md
# Same-Sign Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point words of the same sign in one combinational pass. Each word carries a sign bit, an 8-bit exponent stored with a bias of 127 and a 23-bit fraction. The adder splits both words into fields and restores the implicit leading one, giving 24-bit mantissas. It shifts the mantissa of the smaller-exponent operand right until the two line up, adds them, brings the sum back into the range [1, 2), rounds to nearest with ties to even, and packs the result.

The block suits a datapath that accumulates magnitudes of one sign, such as sums of squares or energy totals. The operand encodings that are not ordinary numbers are detected before any arithmetic is done: zero, infinity and NaN. An exponent that overflows after rounding gives an infinity. Operands of opposite sign, subnormal values and status flags are outside the block's function.

Top module: `fpa_add32`

## Requirements
- R1: For two finite, non-zero operands of equal sign (exponent field 1..254 in bits 30:23, fraction in bits 22:0, sign in bit 31), sum_out is the exact sum rounded to nearest with ties to even.
- R2: 0x3FC00000 plus 0x40500000 gives 0x40980000.
- R3: The result exponent starts from the larger operand exponent. When the exponents differ by 26 or more, sum_out equals the larger operand.
- R4: When the mantissa sum reaches 2.0 or more, it is shifted right one place and the exponent rises by one (0x3F800000 plus 0x3F800000 gives 0x40000000).
- R5: An exact halfway remainder rounds to the even fraction: 0x3F800000 plus 0x33800000 gives 0x3F800000, and 0x3F800001 plus 0x33800000 gives 0x3F800002.
- R6: A round-up that carries out of the mantissa renormalises once more: 0x3FFFFFFF plus 0x33800000 gives 0x40000000.
- R7: If the exponent reaches 255 after normalisation or rounding, sum_out is infinity of the operand sign (0x7F800000 or 0xFF800000).
- R8: If either operand has exponent 255 and a non-zero fraction (NaN), sum_out is 0x7FC00000.
- R9: Infinity (exponent 255, fraction 0) plus a finite value or plus infinity of the same sign gives that infinity.
- R10: An operand whose exponent field is 0 is taken as zero, and sum_out is then the other operand unchanged.
- R11: For finite non-zero operands the sign of sum_out equals the operand sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First addend, binary32 encoding |
| op_b | input | 32 | Second addend, binary32 encoding, same sign as op_a |
| sum_out | output | 32 | Rounded sum, binary32 encoding |

## Verification
The two functions that can act on the same addition are the round-up with its mantissa carry and the exponent overflow to infinity. Both fire together when the largest finite value is added to a value exactly half a unit in its last place. The fraction is odd, so the tie rounds up, the carry lifts the exponent to 255, and the result must be a clean infinity and not a word with a stale fraction. The bench drives that pair for both signs next to the separate carry-only and overflow-only cases, and judges every result against an exact wide-integer sum rounded by the bench itself.

// File: rtl/fpadd_pkg.sv
// Package: shared widths and the unpacked operand record for the adder.
// Assumes the binary32 layout; changing the widths changes the format.
package fpadd_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int GRS_W   = 3;
    localparam int EXT_W   = MANT_W + GRS_W;
    localparam int EXPI_W  = EXP_W + 2;
    localparam logic [EXP_W-1:0]  EXP_ONES = {EXP_W{1'b1}};
    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
        logic              is_zero;
        logic              is_inf;
        logic              is_nan;
    } fp_op_t;
endpackage

// File: rtl/fpa_unpack.sv
// Module: splits one word into sign, exponent and 24-bit mantissa and
// classifies it. Assumes exponent 0 means zero (no subnormal support).
module fpa_unpack
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_op_t            op
);
    logic [FRAC_W-1:0] frac;

    // Field extraction and class decode.
    always_comb begin
        frac       = word[FRAC_W-1:0];
        op.sign    = word[WORD_W-1];
        op.expo    = word[WORD_W-2:FRAC_W];
        op.mant    = {1'b1, frac};
        op.is_zero = (op.expo == '0);
        op.is_inf  = (op.expo == EXP_ONES) && (frac == '0);
        op.is_nan  = (op.expo == EXP_ONES) && (frac != '0);
    end
endmodule

// File: rtl/fpa_align.sv
// Module: picks the larger-exponent operand and shifts the other mantissa
// right by the exponent difference, keeping guard, round and sticky bits.
// Assumes both operands are finite and non-zero.
module fpa_align
    import fpadd_pkg::*;
(
    input  fp_op_t             x,
    input  fp_op_t             y,
    output logic [EXT_W-1:0]   big_ext,
    output logic [EXT_W-1:0]   small_ext,
    output logic [EXPI_W-1:0]  exp_big
);
    logic              swap;
    logic [EXP_W-1:0]  e_hi, e_lo, diff;
    logic [MANT_W-1:0] m_hi, m_lo;
    logic [EXT_W-1:0]  raw_lo, shifted, lost_mask;
    logic              sticky;

    // Ordering by exponent and right shift with sticky collection.
    always_comb begin
        swap      = (y.expo > x.expo);
        e_hi      = swap ? y.expo : x.expo;
        e_lo      = swap ? x.expo : y.expo;
        m_hi      = swap ? y.mant : x.mant;
        m_lo      = swap ? x.mant : y.mant;
        diff      = e_hi - e_lo;
        raw_lo    = {m_lo, {GRS_W{1'b0}}};
        lost_mask = '0;
        if (32'(diff) >= EXT_W) begin
            shifted = '0;
            sticky  = 1'b1;
        end else begin
            shifted   = raw_lo >> diff;
            lost_mask = ~({EXT_W{1'b1}} << diff);
            sticky    = |(raw_lo & lost_mask);
        end
        small_ext = {shifted[EXT_W-1:1], shifted[0] | sticky};
        big_ext   = {m_hi, {GRS_W{1'b0}}};
        exp_big   = {{(EXPI_W-EXP_W){1'b0}}, e_hi};
    end

    // Alignment never enlarges the smaller operand (R3).
    always_comb begin
        a_r3_small_not_grown: assert (small_ext <= raw_lo)
            else $error("aligned mantissa larger than source");
    end
endmodule

// File: rtl/fpa_norm_round.sv
// Module: adds the aligned mantissas, renormalises on carry, rounds to
// nearest even, renormalises again on rounding carry and packs the word.
// Assumes both mantissas have their hidden one in place.
module fpa_norm_round
    import fpadd_pkg::*;
(
    input  logic [EXT_W-1:0]  big_ext,
    input  logic [EXT_W-1:0]  small_ext,
    input  logic [EXPI_W-1:0] exp_big,
    input  logic              sign,
    output logic [WORD_W-1:0] word
);
    logic [EXT_W:0]    raw_sum;
    logic [EXT_W-1:0]  norm;
    logic [EXPI_W-1:0] e_norm, e_fin;
    logic [MANT_W-1:0] m_keep, m_fin;
    logic [MANT_W:0]   m_rnd;
    logic              guard, rest, round_up;

    // Add, first renormalisation, rounding, second renormalisation, pack.
    always_comb begin
        raw_sum = {1'b0, big_ext} + {1'b0, small_ext};
        if (raw_sum[EXT_W]) begin
            norm   = {raw_sum[EXT_W:2], raw_sum[1] | raw_sum[0]};
            e_norm = exp_big + 1'b1;
        end else begin
            norm   = raw_sum[EXT_W-1:0];
            e_norm = exp_big;
        end
        m_keep   = norm[EXT_W-1:GRS_W];
        guard    = norm[GRS_W-1];
        rest     = |norm[GRS_W-2:0];
        round_up = guard & (rest | m_keep[0]);
        m_rnd    = {1'b0, m_keep} + {{MANT_W{1'b0}}, round_up};
        if (m_rnd[MANT_W]) begin
            m_fin = m_rnd[MANT_W:1];
            e_fin = e_norm + 1'b1;
        end else begin
            m_fin = m_rnd[MANT_W-1:0];
            e_fin = e_norm;
        end
        if (e_fin >= {{(EXPI_W-EXP_W){1'b0}}, EXP_ONES})
            word = {sign, EXP_ONES, {FRAC_W{1'b0}}};
        else
            word = {sign, e_fin[EXP_W-1:0], m_fin[FRAC_W-1:0]};
    end

    // Normalised result keeps its hidden one (R4) and a rounding carry
    // leaves a zero fraction (R6).
    always_comb begin
        a_r4_hidden_one: assert (m_fin[MANT_W-1])
            else $error("result mantissa not normalised");
        a_r6_carry_clears_frac: assert (!m_rnd[MANT_W] || m_fin[FRAC_W-1:0] == '0)
            else $error("rounding carry left fraction bits");
    end
endmodule

// File: rtl/fpa_add32.sv
// Module: top of the same-sign adder. Decodes special operands and selects
// between them and the arithmetic path. Assumes op_a and op_b share a sign.
module fpa_add32
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] sum_out
);
    fp_op_t            opa, opb;
    logic [EXT_W-1:0]  big_ext, small_ext;
    logic [EXPI_W-1:0] exp_big;
    logic [WORD_W-1:0] arith_word;

    fpa_unpack u_unpack_a (.word(op_a), .op(opa));
    fpa_unpack u_unpack_b (.word(op_b), .op(opb));

    fpa_align u_align (
        .x(opa), .y(opb),
        .big_ext(big_ext), .small_ext(small_ext), .exp_big(exp_big)
    );

    fpa_norm_round u_round (
        .big_ext(big_ext), .small_ext(small_ext), .exp_big(exp_big),
        .sign(opa.sign), .word(arith_word)
    );

    // Priority selection: NaN, infinity, zero operand, then arithmetic.
    always_comb begin
        if (opa.is_nan || opb.is_nan)
            sum_out = QNAN_WORD;
        else if (opa.is_inf)
            sum_out = op_a;
        else if (opb.is_inf)
            sum_out = op_b;
        else if (opa.is_zero)
            sum_out = op_b;
        else if (opb.is_zero)
            sum_out = op_a;
        else
            sum_out = arith_word;
    end

    // Port-level checks on special handling and sign.
    always_comb begin
        a_r8_nan_quiet: assert (!(opa.is_nan || opb.is_nan) || sum_out == QNAN_WORD)
            else $error("NaN input did not give quiet NaN");
        a_r9_inf_kept: assert (!((opa.is_inf || opb.is_inf) && !opa.is_nan && !opb.is_nan)
                               || (sum_out[WORD_W-2:FRAC_W] == EXP_ONES
                                   && sum_out[FRAC_W-1:0] == '0))
            else $error("infinity input did not give infinity");
        a_r11_sign_kept: assert (!(op_a[WORD_W-1] == op_b[WORD_W-1]
                                   && opa.expo != EXP_ONES && opb.expo != EXP_ONES)
                                 || sum_out[WORD_W-1] == op_a[WORD_W-1])
            else $error("result sign differs from operands");
    end
endmodule

// File: tb/sim_fpa_add32.sv
`timescale 1ns/1ps
module sim_fpa_add32;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [31:0] sum_out;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    fpa_add32 u0 (.op_a(op_a), .op_b(op_b), .sum_out(sum_out));

    // Exact reference: wide integer sum, then round to nearest even.
    function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b);
        logic [7:0]  ea, eb, e_hi, e_lo;
        logic [79:0] s, kept, rem, half, one;
        logic [23:0] m_hi, m_lo;
        int          d, p, sh, e;
        logic        sg;
        ea = a[30:23]; eb = b[30:23]; sg = a[31];
        if ((ea == 8'hFF && a[22:0] != 0) || (eb == 8'hFF && b[22:0] != 0))
            return 32'h7FC00000;
        if (ea == 8'hFF) return a;
        if (eb == 8'hFF) return b;
        if (ea == 0) return b;
        if (eb == 0) return a;
        if (eb > ea) begin
            e_hi = eb; e_lo = ea; m_hi = {1'b1, b[22:0]}; m_lo = {1'b1, a[22:0]};
        end else begin
            e_hi = ea; e_lo = eb; m_hi = {1'b1, a[22:0]}; m_lo = {1'b1, b[22:0]};
        end
        d = int'(e_hi) - int'(e_lo);
        if (d > 40) return (eb > ea) ? b : a;
        s = ({56'b0, m_hi} << d) + {56'b0, m_lo};
        p = 0;
        for (int i = 0; i < 80; i++) if (s[i]) p = i;
        e = int'(e_lo) + p - 23;
        kept = s;
        if (p > 23) begin
            sh   = p - 23;
            one  = 80'd1;
            kept = s >> sh;
            rem  = s & ((one << sh) - one);
            half = one << (sh - 1);
            if (rem > half || (rem == half && kept[0])) kept = kept + 1;
            if (kept[24]) begin kept = kept >> 1; e = e + 1; end
        end
        if (e >= 255) return {sg, 8'hFF, 23'b0};
        return {sg, e[7:0], kept[22:0]};
    endfunction

    task automatic check_add(input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] expv, input string tag);
        @(posedge clk);
        #1 op_a = a; op_b = b;
        #3;
        n_checks++;
        if (sum_out !== expv) begin
            n_errors++;
            $display("FAIL %s: %h + %h actual=%h expected=%h", tag, a, b, sum_out, expv);
        end
    endtask

    function automatic logic [31:0] rnd_word(input logic sg, input logic [7:0] ex);
        logic [22:0] f;
        f = 23'($urandom);
        return {sg, ex, f};
    endfunction

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1789);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-time state: zero plus zero gives zero (R10).
        check_add(32'h00000000, 32'h00000000, 32'h00000000, "R10 zero+zero");
        check_add(32'h3FC00000, 32'h40500000, 32'h40980000, "R2 worked example");
        check_add(32'h3F800000, 32'h3F800000, 32'h40000000, "R4 carry renorm");
        check_add(32'h3F800000, 32'h33800000, 32'h3F800000, "R5 tie to even down");
        check_add(32'h3F800001, 32'h33800000, 32'h3F800002, "R5 tie to even up");
        check_add(32'h3FFFFFFF, 32'h33800000, 32'h40000000, "R6 rounding carry");
        check_add(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, "R7 overflow positive");
        check_add(32'hFF7FFFFF, 32'hFF000000, 32'hFF800000, "R7 overflow negative");
        check_add(32'h7F7FFFFF, 32'h73000000, 32'h7F800000, "R7 R6 carry into infinity");
        check_add(32'hFF7FFFFF, 32'hF3000000, 32'hFF800000, "R7 R6 carry into -infinity");
        check_add(32'h7F800001, 32'h3F800000, 32'h7FC00000, "R8 NaN a");
        check_add(32'h3F800000, 32'h7FC12345, 32'h7FC00000, "R8 NaN b");
        check_add(32'h7F800000, 32'h3F800000, 32'h7F800000, "R9 inf+finite");
        check_add(32'hBF800000, 32'hFF800000, 32'hFF800000, "R9 finite+-inf");
        check_add(32'h7F800000, 32'h7F800000, 32'h7F800000, "R9 inf+inf");
        check_add(32'h00000000, 32'h40490FDB, 32'h40490FDB, "R10 zero a");
        check_add(32'hC1234567, 32'h80000000, 32'hC1234567, "R10 -zero b");
        check_add(32'h00400000, 32'h3F800000, 32'h3F800000, "R10 exp0 as zero");
        check_add(32'h4B800000, 32'h3F800000, 32'h4B800000, "R3 diff 24 tie");
        check_add(32'h4C800000, 32'h3F812345, 32'h4C800000, "R3 diff 26");
        check_add(32'h3F812345, 32'h6E000000, 32'h6E000000, "R3 large diff swapped");
        check_add(32'hC0000000, 32'hC0400000, 32'hC0A00000, "R11 negative sum");
        // Mixed random same-sign operands: near exponents, wide spreads, top range.
        for (int k = 0; k < 3000; k++) begin
            logic        sg;
            logic [7:0]  ea, eb;
            logic [31:0] a, b;
            int          mode, off;
            sg   = 1'($urandom);
            mode = int'($urandom % 3);
            ea   = 8'(1 + ($urandom % 254));
            if (mode == 0) begin
                off = int'($urandom % 6) - 3;
                eb  = (int'(ea) + off < 1 || int'(ea) + off > 254) ? ea : 8'(int'(ea) + off);
            end else if (mode == 1) begin
                eb = 8'(1 + ($urandom % 254));
            end else begin
                ea = 8'(250 + ($urandom % 5));
                eb = 8'(250 + ($urandom % 5));
            end
            a = rnd_word(sg, ea);
            b = rnd_word(sg, eb);
            check_add(a, b, ref_add(a, b), (mode == 2) ? "R7 R1 random high" : "R1 R3 R11 random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule